// File: doc/BRIEF.md
# Physical Page Pointer Walker

This block turns one transfer descriptor into a stream of (address, length) segments for a DMA engine. The descriptor has three parts: a byte count, a first pointer that may start anywhere inside a memory page, and a second pointer. Depending on how many bytes are left after the first page, the second pointer is used in one of two ways. It can be the single page that holds the rest of the data. It can also be the address of a list of 64-bit page pointers. A list page ends in a link slot, so a list of any length can be built as a chain of list pages.

The walker reads list entries one at a time through a simple memory-read port. Each response is one 64-bit little-endian word, and bit 0 of the word is the least significant address bit. The walker checks every pointer it uses. A zero pointer or a pointer that is not page-aligned, where the rules require alignment, ends the walk at once with an error. Segments go out under a valid/ready handshake. Each walk ends with a one-cycle completion pulse that carries an error flag.

Top module: `prp_walk`

## Requirements
- R1: The first segment starts at the first pointer and is min(byte count, page size − (first pointer mod page size)) bytes long.
- R2: A zero first pointer ends the walk with the error flag set and no segment emitted. The completion pulse appears in the cycle after the start is accepted.
- R3: If bytes remain after the first segment and the second pointer is zero, the walk ends with an error and no segment.
- R4: If the remaining bytes fit within one page, the second pointer becomes one segment carrying all of them. This pointer must be page-aligned; if it is not, the walk ends with an error and no segment.
- R5: If more than one page remains, the second pointer is the base of a list of 8-byte entries. Entry k is read at base + 8·k. Each entry is one segment of min(remaining, page size) bytes, and only one read is outstanding at a time.
- R6: A list page holds page size / 8 slots. If the last slot is reached while more than one page still remains, that slot's word is taken as the base of the next list page, and reading restarts at its slot 0. The link word itself is never emitted as a segment.
- R7: A list entry or link that is zero or not page-aligned ends the walk with an error in the cycle after its read response. Segments already emitted stay valid, and no further segment is emitted.
- R8: The page size is 2^(12 + mps), where mps is a 3-bit input sampled at start. No segment is longer than one page.
- R9: While a segment is valid and not accepted, its valid, address and length stay unchanged.
- R10: Every walk ends with a `done` pulse exactly one cycle long. `err` is high only together with `done`, and only for an aborted walk. A `start` while busy is ignored.
- R11: A byte count of zero with a non-zero first pointer completes without error and with no segment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| xfer_len | input | 32 | Transfer byte count |
| ptr1 | input | 64 | First pointer, may carry a page offset |
| ptr2 | input | 64 | Second pointer: direct page or list base |
| mps | input | 3 | Page size select, page = 2^(12+mps) |
| busy | output | 1 | A walk is in progress |
| seg_valid | output | 1 | Segment available |
| seg_ready | input | 1 | Consumer accepts the segment |
| seg_addr | output | 64 | Segment start address |
| seg_len | output | 32 | Segment byte count |
| mem_rd_valid | output | 1 | One-cycle read request for a list word |
| mem_rd_addr | output | 64 | Address of the list word |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 64 | Read word (little-endian pointer) |
| done | output | 1 | Walk finished (one-cycle pulse) |
| err | output | 1 | Walk aborted (valid with done) |

## Verification
After a start is accepted, the first segment, or the completion pulse for an up-front rejection, shows up in the very next cycle. A read request lasts one cycle, and the segment or abort it leads to appears one cycle after the response is taken. The segment handshake advances only on a cycle where valid and ready are both high. The bench samples every output on the falling edge and answers a read on the falling edge one cycle after it sees the request. It records a segment only when valid and its own ready are both high for the next rising edge, so segments are counted exactly at handshake cycles. It compares the recorded list, the error flag and, for up-front decisions, the pulse latency against an expected walk that it computes itself.

// File: rtl/prp_walk_pkg.sv
package prp_walk_pkg;
  parameter int PW_ADDR_W     = 64;
  parameter int PW_LEN_W      = 32;
  parameter int PW_MPS_W      = 3;
  parameter int PW_PAGE_SHIFT = 12;
  localparam int PW_ENTRY_SHIFT = 3;
  localparam int PW_SLOT_W = PW_PAGE_SHIFT - PW_ENTRY_SHIFT + (1 << PW_MPS_W) - 1;

  typedef logic [PW_ADDR_W-1:0] addr_t;
  typedef logic [PW_LEN_W-1:0]  len_t;
  typedef logic [PW_MPS_W-1:0]  mps_t;
  typedef logic [PW_SLOT_W-1:0] slot_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_HEAD, ST_DIRECT, ST_FETCH, ST_WAIT, ST_DATA, ST_END
  } walk_st_e;

  // bytes in one page for a given size select
  function automatic len_t page_bytes(mps_t m);
    return len_t'(1) << (PW_PAGE_SHIFT + int'(m));
  endfunction

  // byte position of an address inside its page
  function automatic len_t page_offset(addr_t a, mps_t m);
    return a[PW_LEN_W-1:0] & (page_bytes(m) - len_t'(1));
  endfunction

  function automatic len_t len_min(len_t a, len_t b);
    return (a < b) ? a : b;
  endfunction

  // bytes from an address up to the end of its page, capped by total
  function automatic len_t head_bytes(len_t total, addr_t a, mps_t m);
    return len_min(total, page_bytes(m) - page_offset(a, m));
  endfunction

  // index of the final 8-byte slot in a list page
  function automatic slot_t last_slot_idx(mps_t m);
    return slot_t'((len_t'(1) << (PW_PAGE_SHIFT - PW_ENTRY_SHIFT + int'(m))) - len_t'(1));
  endfunction
endpackage

// File: rtl/prp_len_calc.sv
module prp_len_calc
  import prp_walk_pkg::*;
(
  input  len_t  total,
  input  addr_t start_addr,
  input  mps_t  mps,
  output len_t  head_len,
  output len_t  tail_len
);
  assign head_len = head_bytes(total, start_addr, mps);
  assign tail_len = total - head_len;
endmodule

// File: rtl/prp_ptr_check.sv
module prp_ptr_check
  import prp_walk_pkg::*;
(
  input  addr_t ptr,
  input  mps_t  mps,
  output logic  is_null,
  output logic  off_page
);
  assign is_null  = (ptr == '0);
  assign off_page = (page_offset(ptr, mps) != '0);
endmodule

// File: rtl/prp_slot_ctr.sv
module prp_slot_ctr
  import prp_walk_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  active,
  input  logic  load,
  input  addr_t load_base,
  input  logic  step,
  input  mps_t  mps,
  output addr_t fetch_addr,
  output logic  at_last
);
  localparam int PAD_W = PW_ADDR_W - PW_SLOT_W - PW_ENTRY_SHIFT;

  addr_t base_q;
  slot_t slot_q;
  slot_t slot_lim;

  assign slot_lim = last_slot_idx(mps);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      slot_q <= '0;
    end else if (load) begin
      base_q <= load_base;
      slot_q <= '0;
    end else if (step) begin
      slot_q <= slot_q + slot_t'(1);
    end
  end

  assign fetch_addr = base_q + {{PAD_W{1'b0}}, slot_q, {PW_ENTRY_SHIFT{1'b0}}};
  assign at_last    = (slot_q == slot_lim);

  // R6
  slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (slot_q <= slot_lim));
endmodule

// File: rtl/prp_walk.sv
module prp_walk
  import prp_walk_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] xfer_len,
  input  logic [63:0] ptr1,
  input  logic [63:0] ptr2,
  input  logic [2:0]  mps,
  output logic        busy,
  output logic        seg_valid,
  input  logic        seg_ready,
  output logic [63:0] seg_addr,
  output logic [31:0] seg_len,
  output logic        mem_rd_valid,
  output logic [63:0] mem_rd_addr,
  input  logic        mem_rsp_valid,
  input  logic [63:0] mem_rsp_data,
  output logic        done,
  output logic        err
);
  walk_st_e st_q;
  len_t     rem_q, seg_len_q;
  addr_t    seg_addr_q, ptr2_q;
  mps_t     mps_q;
  logic     err_q;

  // start-time arithmetic on the raw inputs
  len_t in_head, in_tail;
  logic p2_null, p2_off;
  prp_len_calc u_calc_in (
    .total(xfer_len), .start_addr(ptr1), .mps(mps),
    .head_len(in_head), .tail_len(in_tail));
  prp_ptr_check u_chk_p2 (
    .ptr(ptr2), .mps(mps), .is_null(p2_null), .off_page(p2_off));

  // per-entry arithmetic on the running remainder
  len_t chunk_len, rem_after;
  prp_len_calc u_calc_rem (
    .total(rem_q), .start_addr('0), .mps(mps_q),
    .head_len(chunk_len), .tail_len(rem_after));

  logic ent_null, ent_off;
  prp_ptr_check u_chk_ent (
    .ptr(mem_rsp_data), .mps(mps_q), .is_null(ent_null), .off_page(ent_off));

  // named internal events
  logic in_has_tail, in_tail_fits, start_err, accept, seg_fire, rsp_take;
  logic entry_bad, rem_one_page, link_evt, data_evt, abort_evt, list_enter;
  logic slot_load, at_last, slot_active;
  addr_t fetch_addr;

  assign in_has_tail  = (in_tail != '0);
  assign in_tail_fits = (in_tail <= page_bytes(mps));
  assign start_err    = (ptr1 == '0) | (in_has_tail & p2_null) |
                        (in_has_tail & in_tail_fits & p2_off);
  assign accept       = (st_q == ST_IDLE) & start;
  assign seg_fire     = seg_valid & seg_ready;
  assign rsp_take     = (st_q == ST_WAIT) & mem_rsp_valid;
  assign entry_bad    = ent_null | ent_off;
  assign rem_one_page = (rem_after == '0);
  assign link_evt     = rsp_take & ~entry_bad & at_last & ~rem_one_page;
  assign data_evt     = rsp_take & ~entry_bad & ~(at_last & ~rem_one_page);
  assign abort_evt    = (accept & start_err) | (rsp_take & entry_bad);
  assign list_enter   = (st_q == ST_HEAD) & seg_ready & (rem_q != '0) & ~rem_one_page;
  assign slot_load    = list_enter | link_evt;
  assign slot_active  = (st_q == ST_FETCH) | (st_q == ST_WAIT);

  prp_slot_ctr u_slots (
    .clk(clk), .rst_n(rst_n), .active(slot_active),
    .load(slot_load), .load_base(link_evt ? mem_rsp_data : ptr2_q),
    .step(data_evt), .mps(mps_q),
    .fetch_addr(fetch_addr), .at_last(at_last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      rem_q      <= '0;
      seg_len_q  <= '0;
      seg_addr_q <= '0;
      ptr2_q     <= '0;
      mps_q      <= '0;
      err_q      <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start) begin
          mps_q  <= mps;
          ptr2_q <= ptr2;
          err_q  <= 1'b0;
          if (start_err) begin
            err_q <= 1'b1;
            st_q  <= ST_END;
          end else if (xfer_len == '0) begin
            st_q <= ST_END;
          end else begin
            seg_addr_q <= ptr1;
            seg_len_q  <= in_head;
            rem_q      <= in_tail;
            st_q       <= ST_HEAD;
          end
        end
        ST_HEAD: if (seg_ready) begin
          if (rem_q == '0) begin
            st_q <= ST_END;
          end else if (rem_one_page) begin
            seg_addr_q <= ptr2_q;
            seg_len_q  <= rem_q;
            st_q       <= ST_DIRECT;
          end else begin
            st_q <= ST_FETCH;
          end
        end
        ST_DIRECT: if (seg_ready) st_q <= ST_END;
        ST_FETCH:  st_q <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (entry_bad) begin
            err_q <= 1'b1;
            st_q  <= ST_END;
          end else if (link_evt) begin
            st_q <= ST_FETCH;
          end else begin
            seg_addr_q <= mem_rsp_data;
            seg_len_q  <= chunk_len;
            st_q       <= ST_DATA;
          end
        end
        ST_DATA: if (seg_ready) begin
          rem_q <= rem_q - seg_len_q;
          st_q  <= (rem_q == seg_len_q) ? ST_END : ST_FETCH;
        end
        ST_END:  st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy         = (st_q != ST_IDLE);
  assign seg_valid    = (st_q == ST_HEAD) | (st_q == ST_DIRECT) | (st_q == ST_DATA);
  assign seg_addr     = seg_addr_q;
  assign seg_len      = seg_len_q;
  assign mem_rd_valid = (st_q == ST_FETCH);
  assign mem_rd_addr  = fetch_addr;
  assign done         = (st_q == ST_END);
  assign err          = done & err_q;

  // R9
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len)));
  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);
  // R7
  abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_evt |=> (done && err && !seg_valid));
  // R6
  link_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    link_evt |=> (mem_rd_valid && !seg_valid));
  // R5
  fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> (!mem_rd_valid && !seg_valid));
  // R8
  seg_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seg_valid |-> ((seg_len != '0) && (seg_len <= page_bytes(mps_q))));
  // R1
  head_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HEAD) |-> ((page_offset(seg_addr, mps_q) + seg_len) <= page_bytes(mps_q)));
  // R4
  direct_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_DIRECT) |-> (page_offset(seg_addr, mps_q) == '0));
endmodule

// File: tb/tb_prp_walk.sv
module tb_prp_walk;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] xfer_len = '0;
  logic [63:0] ptr1 = '0, ptr2 = '0;
  logic [2:0]  mps_in = '0;
  logic        busy, seg_valid, mem_rd_valid, done, err;
  logic        seg_ready = 1'b0;
  logic [63:0] seg_addr, mem_rd_addr;
  logic [31:0] seg_len;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #2 clk = ~clk;

  prp_walk dut (
    .clk(clk), .rst_n(rst_n), .start(start), .xfer_len(xfer_len),
    .ptr1(ptr1), .ptr2(ptr2), .mps(mps_in), .busy(busy),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr),
    .seg_len(seg_len), .mem_rd_valid(mem_rd_valid), .mem_rd_addr(mem_rd_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .err(err));

  int n_tests = 0, n_fail = 0;
  int unsigned cyc_total = 0;
  int cur_mps = 0;
  logic [63:0] poison_addr = '1, poison_val = '0;
  logic [63:0] exp_a [1024];
  logic [31:0] exp_l [1024];
  logic [63:0] got_a [1024];
  logic [31:0] got_l [1024];
  int exp_n, got_n, done_at;
  bit exp_err, got_err;

  always @(posedge clk) begin
    cyc_total <= cyc_total + 1;
    if (cyc_total > 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL R10 watchdog: cycles %0d expected below %0d", cyc_total, 150000);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [63:0] act, logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // list memory model: a word whose successor address starts a page links there
  function automatic logic [63:0] mem_word(logic [63:0] a);
    logic [63:0] pg;
    pg = 64'd1 << (12 + cur_mps);
    if (a == poison_addr) return poison_val;
    if (((a + 64'd8) & (pg - 64'd1)) == 64'd0) return a + 64'd8;
    return a << 16;
  endfunction

  task automatic push_exp(logic [63:0] a, logic [63:0] l);
    if (exp_n < 1024) begin
      exp_a[exp_n] = a;
      exp_l[exp_n] = l[31:0];
    end
    exp_n++;
  endtask

  // expected walk, restated from the requirements
  task automatic ref_walk(logic [63:0] len, logic [63:0] p1, logic [63:0] p2, int m);
    logic [63:0] pg, rem, f, base, e, c;
    int slot, last;
    exp_n = 0; exp_err = 0;
    pg = 64'd1 << (12 + m);
    last = int'(pg / 8) - 1;
    if (p1 == 0) begin exp_err = 1; return; end
    if (len == 0) return;
    f = pg - (p1 % pg);
    if (len < f) f = len;
    rem = len - f;
    if (rem != 0 && p2 == 0) begin exp_err = 1; return; end
    if (rem != 0 && rem <= pg && (p2 % pg) != 0) begin exp_err = 1; return; end
    push_exp(p1, f);
    if (rem == 0) return;
    if (rem <= pg) begin push_exp(p2, rem); return; end
    base = p2; slot = 0;
    while (rem != 0 && exp_n < 1100) begin
      e = mem_word(base + 64'(8 * slot));
      if (e == 0 || (e % pg) != 0) begin exp_err = 1; return; end
      if (slot == last && rem > pg) begin
        base = e; slot = 0;
      end else begin
        c = (rem < pg) ? rem : pg;
        push_exp(e, c);
        rem = rem - c;
        slot++;
      end
    end
  endtask

  task automatic run_walk(logic [31:0] len, logic [63:0] p1, logic [63:0] p2,
                          int m, bit bp, bit inj, string tag);
    bit pending, fin;
    logic [63:0] paddr;
    int mism;
    cur_mps = m;
    ref_walk(64'(len), p1, p2, m);
    got_n = 0; got_err = 0; done_at = -1;
    pending = 0; fin = 0; paddr = '0;
    @(negedge clk);
    xfer_len = len; ptr1 = p1; ptr2 = p2; mps_in = 3'(m); start = 1'b1;
    for (int c = 0; c < 40000 && !fin; c++) begin
      @(negedge clk);
      start = inj && (c == 6);
      if (start) begin ptr1 = '0; xfer_len = 32'd5; end
      mem_rsp_valid = 1'b0;
      if (pending) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem_word(paddr);
        pending = 0;
      end
      if (mem_rd_valid) begin pending = 1; paddr = mem_rd_addr; end
      seg_ready = !bp || ((c % 3) != 1);
      if (seg_valid && seg_ready) begin
        if (got_n < 1024) begin got_a[got_n] = seg_addr; got_l[got_n] = seg_len; end
        got_n++;
      end
      if (done) begin got_err = err; fin = 1; done_at = c; end
    end
    start = 1'b0; seg_ready = 1'b0; mem_rsp_valid = 1'b0;
    mism = 0;
    for (int i = 0; i < got_n && i < exp_n && i < 1024; i++)
      if (got_a[i] != exp_a[i] || got_l[i] != exp_l[i]) mism++;
    chk(fin, tag, "walk completed", 64'(fin), 64'd1);
    chk(got_n == exp_n, tag, "segment count", 64'(got_n), 64'(exp_n));
    chk(mism == 0, tag, "mismatched segments", 64'(mism), 64'd0);
    chk(got_err == exp_err, tag, "error flag", 64'(got_err), 64'(exp_err));
  endtask

  localparam int NV = 11;
  // {len, ptr1, ptr2, mps, backpressure}
  localparam logic [163:0] VEC [NV] = '{
    {32'd100,   64'h1000_0010, 64'h0,          3'd0, 1'b0},
    {32'd4096,  64'h1000_0800, 64'h2000_0000,  3'd0, 1'b1},
    {32'd4096,  64'h0000_3000, 64'h0,          3'd0, 1'b0},
    {32'd16384, 64'h5000_0100, 64'h0040_0000,  3'd0, 1'b1},
    {32'd20000, 64'h6000_0000, 64'h0080_0000,  3'd1, 1'b1},
    {32'd512,   64'h0,         64'h2000_0000,  3'd0, 1'b0},
    {32'd8192,  64'h1000_0000, 64'h0,          3'd0, 1'b0},
    {32'd6000,  64'h1000_0000, 64'h2000_0010,  3'd0, 1'b0},
    {32'd0,     64'h1000_0000, 64'h0,          3'd0, 1'b0},
    {32'd12288, 64'h1000_0000, 64'h0040_0100,  3'd0, 1'b0},
    {32'd8192,  64'h1000_1800, 64'h2000_2000,  3'd1, 1'b0}
  };

  function automatic string vec_tag(int i);
    case (i)
      0, 2:    return "R1";
      1:       return "R4";
      3, 9:    return "R5";
      4:       return "R9";
      5:       return "R2";
      6:       return "R3";
      7:       return "R4";
      8:       return "R11";
      default: return "R8";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 idle state after reset
    chk(!seg_valid && !done && !err && !mem_rd_valid && !busy, "R10", "reset outputs",
        {59'd0, seg_valid, done, err, mem_rd_valid, busy}, 64'd0);

    for (int i = 0; i < NV; i++) begin
      run_walk(VEC[i][163:132], VEC[i][131:68], VEC[i][67:4],
               int'(VEC[i][3:1]), VEC[i][0], 1'b0, vec_tag(i));
      if (exp_n == 0)
        chk(done_at == 0, vec_tag(i), "completion latency", 64'(done_at), 64'd0);
    end

    // R6 chained list with a start pulse mid-walk (R10 ignored start)
    run_walk(32'd514 * 32'd4096, 64'h7000_0000, 64'h0100_0000, 0, 1'b0, 1'b1, "R6");
    chk(got_n == 514, "R6", "chain segment total", 64'(got_n), 64'd514);

    // R7 zero entry in the third slot
    poison_addr = 64'h0040_0010; poison_val = 64'h0;
    run_walk(32'd16384, 64'h5000_0000, 64'h0040_0000, 0, 1'b1, 1'b0, "R7");
    chk(got_n == 3, "R7", "segments before abort", 64'(got_n), 64'd3);

    // R7 misaligned link word
    poison_addr = 64'h0100_0FF8; poison_val = 64'h0200_0010;
    run_walk(32'd514 * 32'd4096, 64'h7000_0000, 64'h0100_0000, 0, 1'b0, 1'b0, "R7");
    chk(got_n == 512, "R7", "segments before link abort", 64'(got_n), 64'd512);

    // R8 entry aligned to 4 KiB but not to the 8 KiB page
    poison_addr = 64'h0080_0000; poison_val = 64'h0000_3000;
    run_walk(32'd20000, 64'h6000_0000, 64'h0080_0000, 1, 1'b0, 1'b0, "R8");
    chk(got_err == 1'b1, "R8", "large-page alignment abort", 64'(got_err), 64'd1);
    poison_addr = '1;

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule